// File: doc/BRIEF.md
# Indexed Codec Control Register File

This block is the byte-wide host-facing control interface of an audio codec. The host sees four direct ports selected by a 2-bit address: an index pointer (0), a data window onto the selected indirect register (1), a status byte (2) and a programmed-I/O data byte (3). Behind the data window sits a bank of 8-bit indirect control registers. The pointer reaches either 16 or 32 of them, depending on a mode bit held in the bank itself.

The bank applies a write rule to each register. Some registers are fixed, some have bits forced to 0, and some ignore writes. The sample-format register only takes a write while a mode-change-enable bit is set, or partially while a playback-only variant of that bit is set. Every accepted format write produces a one-cycle `fmt_reload` pulse toward the playback datapath. The `play_en` output follows the enable bit of the interface-configuration register.

A terminal-count pulse from the playback datapath raises an interrupt. The host clears it by writing the status port, or by writing a 0 over the playback interrupt flag. When mode-change-enable is set from a cleared state while auto-calibration is configured, a calibration-busy flag reads as set for a programmable number of reads of the error-status register.

Top module: `codec_regfile`

## Requirements
- R1: Port map: address 0 is the index pointer, 1 is the indirect data window, 2 is status and 3 is programmed-I/O data. After reset the pointer reads 0x40, so mode-change-enable (pointer bit 6) is set. Indirect register 12 reads 0x8A, 25 reads 0xA0 and 9 reads 0x08. Registers 2 to 5, 18 and 19 read 0x88, registers 6 and 7 read 0x80, and all others read 0.
- R2: Pointer bit 7 is dropped on write and always reads 0.
- R3: The indirect index is pointer bits 3:0 while bit 6 of register 12 is 0, and pointer bits 4:0 while it is 1.
- R4: In register 12 only bit 6 is writable. The other bits keep their reset value.
- R5: Writes to registers 22, 27 and 29 and to the read-only register 11 leave them unchanged.
- R6: A write to register 9 stores bit 5 as 0. `play_en` equals bit 0 of register 9.
- R7: A write to register 8 is stored whole while pointer bit 6 is 1. Otherwise, if bit 4 of register 24 is 1, only bits 7:4 are updated. Otherwise the write is discarded.
- R8: Every accepted write to register 8 gives `fmt_reload` high for exactly the one cycle after the write edge. A discarded write gives no pulse.
- R9: A `pb_tc` pulse sets status bit 0, bit 4 of register 24 and `irq`. This set wins over a clear in the same cycle.
- R10: Any write to the status port clears status bit 0, clears bits 6:4 of register 24 (keeping its other bits) and drops `irq`.
- R11: A write to register 24 that takes bit 4 from 1 to 0 clears status bit 0 and `irq`. A write that leaves bit 4 at 1 does not.
- R12: A pointer write that takes bit 6 from 0 to 1 while bits 4:3 of register 9 are nonzero loads a counter with CAL_COUNT (default 1). While the counter is nonzero, reads of register 11 return bit 5 set, and each such read decrements it. A pointer write with bit 6 already 1, or with register 9 bits 4:3 zero, loads nothing.
- R13: The programmed-I/O port reads 0. Status bits 7:1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Direct port select |
| rd | input | 1 | Read strobe; side effects at the clock edge |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| pb_tc | input | 1 | Playback terminal-count pulse from the datapath |
| rdata | output | 8 | Read data, combinational while `rd` is high, else 0 |
| irq | output | 1 | Interrupt line |
| play_en | output | 1 | Playback enable level |
| fmt_reload | output | 1 | One-cycle pulse after an accepted format write |

## Verification
The hardest state to reach from the ports is partial acceptance of a format write. It needs pointer bit 6 cleared while register 24 bit 4 is set. Because register 24 is above index 15, the stimulus first widens the index by setting bit 6 of register 12. It then sets the flag in register 24 and writes register 8 through a pointer value with bit 6 clear.

The calibration flag is reached the same way. The bench first clears pointer bit 6 and loads register 9 bits 4:3, and only then re-arms the pointer. It also covers both cases that must not load the counter.

// File: rtl/codec_regs_pkg.sv
package codec_regs_pkg;
   localparam int DW   = 8;
   localparam int NREG = 32;
   localparam int IW   = $clog2(NREG);

   localparam logic [IW-1:0] IX_FMT   = 5'd8;
   localparam logic [IW-1:0] IX_IFC   = 5'd9;
   localparam logic [IW-1:0] IX_ERR   = 5'd11;
   localparam logic [IW-1:0] IX_MODE  = 5'd12;
   localparam logic [IW-1:0] IX_RSV0  = 5'd22;
   localparam logic [IW-1:0] IX_ALTST = 5'd24;
   localparam logic [IW-1:0] IX_RSV1  = 5'd27;
   localparam logic [IW-1:0] IX_RSV2  = 5'd29;

   localparam int B_WIDE  = 6;  // register 12: wide index
   localparam int B_MCE   = 6;  // pointer: mode-change enable
   localparam int B_PMCE  = 4;  // register 24: playback-only mode change
   localparam int B_PFLG  = 4;  // register 24: playback interrupt flag
   localparam int B_CAL   = 5;  // register 11: calibration busy
   localparam int B_IFRSV = 5;  // register 9: reserved bit
   localparam int B_PEN   = 0;  // register 9: playback enable

   typedef enum logic [1:0] {
      PORT_PTR  = 2'd0,
      PORT_DATA = 2'd1,
      PORT_STAT = 2'd2,
      PORT_PIO  = 2'd3
   } port_e;

   function automatic logic [DW-1:0] ind_reset(input int i);
      logic [DW-1:0] v;
      v = '0;
      if (i == 12) v = 8'h8A;
      else if (i == 25) v = 8'hA0;
      else if (i == 9) v = 8'h08;
      else if ((i >= 2 && i <= 5) || i == 18 || i == 19) v = 8'h88;
      else if (i == 6 || i == 7) v = 8'h80;
      return v;
   endfunction
endpackage

// File: rtl/codec_index_port.sv
module codec_index_port
   import codec_regs_pkg::*;
#(
   parameter bit ALLOW_WIDE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_ptr,
   input  logic [DW-1:0] wdata,
   input  logic          wide,
   output logic [DW-2:0] ptr_q,
   output logic [IW-1:0] eff_idx,
   output logic          mce,
   output logic          mce_rise
);
   localparam logic [DW-2:0] PTR_RST = 7'h40;

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr_q <= PTR_RST;
      else if (wr_ptr)
         ptr_q <= wdata[DW-2:0];
   end

   assign mce      = ptr_q[B_MCE];
   assign mce_rise = wr_ptr && wdata[B_MCE] && !ptr_q[B_MCE];

   if (ALLOW_WIDE) begin : g_wide
      always_comb begin
         if (wide) eff_idx = ptr_q[IW-1:0];
         else      eff_idx = {1'b0, ptr_q[IW-2:0]};
      end
   end else begin : g_narrow
      logic unused_wide;
      assign unused_wide = wide;
      assign eff_idx = {1'b0, ptr_q[IW-2:0]};
   end
endmodule

// File: rtl/codec_cal_counter.sv
module codec_cal_counter #(
   parameter int CAL_COUNT = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic rd_err,
   output logic busy
);
   localparam int CW = (CAL_COUNT < 1) ? 1 : $clog2(CAL_COUNT + 1);
   localparam logic [CW-1:0] LOADV = CW'(CAL_COUNT);

   if (CAL_COUNT < 0) begin : g_bad_count
      $error("CAL_COUNT must not be negative");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= LOADV;
      else if (rd_err && cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);
endmodule

// File: rtl/codec_ind_bank.sv
module codec_ind_bank
   import codec_regs_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_data,
   input  logic [IW-1:0] eff_idx,
   input  logic [DW-1:0] wdata,
   input  logic          mce,
   input  logic          status_wr,
   input  logic          pb_tc,
   output logic [DW-1:0] rd_val,
   output logic          wide,
   output logic [DW-1:0] ifc_q,
   output logic          fmt_accept,
   output logic          pflag_fall
);
   logic [NREG-1:0][DW-1:0] regs;
   logic pmce;

   assign pmce = regs[IX_ALTST][B_PMCE];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      localparam logic [IW-1:0] GI = IW'(g);
      localparam logic [DW-1:0] RV = ind_reset(g);
      logic [DW-1:0] q;
      logic [DW-1:0] d;
      logic hit;

      assign hit = wr_data && (eff_idx == GI);

      always_comb begin
         d = q;
         if (hit) begin
            if (GI == IX_MODE)
               d[B_WIDE] = wdata[B_WIDE];
            else if (GI == IX_ERR || GI == IX_RSV0 || GI == IX_RSV1 || GI == IX_RSV2)
               d = q;
            else if (GI == IX_IFC)
               d = wdata & ~(DW'(1) << B_IFRSV);
            else if (GI == IX_FMT) begin
               if (mce)       d = wdata;
               else if (pmce) d = {wdata[DW-1:4], q[3:0]};
            end else
               d = wdata;
         end
         if (GI == IX_ALTST) begin
            if (status_wr) d[6:4] = 3'b000;
            if (pb_tc)     d[B_PFLG] = 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) q <= RV;
         else        q <= d;
      end

      assign regs[g] = q;
   end

   assign rd_val     = regs[eff_idx];
   assign wide       = regs[IX_MODE][B_WIDE];
   assign ifc_q      = regs[IX_IFC];
   assign fmt_accept = wr_data && (eff_idx == IX_FMT) && (mce || pmce);
   assign pflag_fall = wr_data && (eff_idx == IX_ALTST)
                       && regs[IX_ALTST][B_PFLG] && !wdata[B_PFLG];
endmodule

// File: rtl/codec_irq_ctl.sv
module codec_irq_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic pb_tc,
   input  logic status_wr,
   input  logic pflag_fall,
   input  logic fmt_accept,
   output logic int_q,
   output logic reload_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         int_q    <= 1'b0;
         reload_q <= 1'b0;
      end else begin
         reload_q <= fmt_accept;
         if (pb_tc)
            int_q <= 1'b1;
         else if (status_wr || pflag_fall)
            int_q <= 1'b0;
      end
   end
endmodule

// File: rtl/codec_regfile.sv
module codec_regfile
   import codec_regs_pkg::*;
#(
   parameter int CAL_COUNT  = 1,
   parameter bit ALLOW_WIDE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] addr,
   input  logic       rd,
   input  logic       wr,
   input  logic [7:0] wdata,
   input  logic       pb_tc,
   output logic [7:0] rdata,
   output logic       irq,
   output logic       play_en,
   output logic       fmt_reload
);
   logic          wr_ptr, wr_data, status_wr, rd_data;
   logic [DW-2:0] ptr_q;
   logic [IW-1:0] eff_idx;
   logic          mce, mce_rise, wide;
   logic [DW-1:0] bank_val, ifc_q;
   logic          fmt_accept, pflag_fall, cal_busy, cal_load, int_q;
   logic [DW-1:0] mux_val;

   assign wr_ptr    = wr && (port_e'(addr) == PORT_PTR);
   assign wr_data   = wr && (port_e'(addr) == PORT_DATA);
   assign status_wr = wr && (port_e'(addr) == PORT_STAT);
   assign rd_data   = rd && (port_e'(addr) == PORT_DATA);

   codec_index_port #(.ALLOW_WIDE(ALLOW_WIDE)) u_ptr (
      .clk(clk), .rst_n(rst_n), .wr_ptr(wr_ptr), .wdata(wdata), .wide(wide),
      .ptr_q(ptr_q), .eff_idx(eff_idx), .mce(mce), .mce_rise(mce_rise)
   );

   codec_ind_bank u_bank (
      .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .eff_idx(eff_idx),
      .wdata(wdata), .mce(mce), .status_wr(status_wr), .pb_tc(pb_tc),
      .rd_val(bank_val), .wide(wide), .ifc_q(ifc_q),
      .fmt_accept(fmt_accept), .pflag_fall(pflag_fall)
   );

   assign cal_load = mce_rise && (ifc_q[4:3] != 2'b00);

   codec_cal_counter #(.CAL_COUNT(CAL_COUNT)) u_cal (
      .clk(clk), .rst_n(rst_n), .load(cal_load),
      .rd_err(rd_data && eff_idx == IX_ERR), .busy(cal_busy)
   );

   codec_irq_ctl u_irq (
      .clk(clk), .rst_n(rst_n), .pb_tc(pb_tc), .status_wr(status_wr),
      .pflag_fall(pflag_fall), .fmt_accept(fmt_accept),
      .int_q(int_q), .reload_q(fmt_reload)
   );

   always_comb begin
      unique case (port_e'(addr))
         PORT_PTR:  mux_val = {1'b0, ptr_q};
         PORT_DATA: mux_val = bank_val
                    | ((cal_busy && eff_idx == IX_ERR) ? (DW'(1) << B_CAL) : '0);
         PORT_STAT: mux_val = {{(DW-1){1'b0}}, int_q};
         default:   mux_val = '0;
      endcase
   end

   assign rdata   = rd ? mux_val : '0;
   assign irq     = int_q;
   assign play_en = ifc_q[B_PEN];
endmodule

// File: rtl/codec_regfile_chk.sv
module codec_regfile_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] addr,
   input logic       rd,
   input logic       wr,
   input logic [7:0] wdata,
   input logic       pb_tc,
   input logic [7:0] rdata,
   input logic       irq,
   input logic       play_en,
   input logic       fmt_reload
);
   logic [7:0] unused_wdata;
   assign unused_wdata = wdata;

   assert_ptr_bit7_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && addr == 2'd0) |-> !rdata[7]);

   assert_pio_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && addr == 2'd3) |-> (rdata == 8'h00));

   assert_reload_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_reload |-> $past(wr && addr == 2'd1));

   assert_pen_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(play_en) |-> $past(wr && addr == 2'd1));

   assert_tc_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pb_tc |=> irq);

   assert_status_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == 2'd2 && !pb_tc) |=> !irq);
endmodule

bind codec_regfile codec_regfile_chk u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
   .pb_tc(pb_tc), .rdata(rdata), .irq(irq), .play_en(play_en),
   .fmt_reload(fmt_reload)
);

// File: tb/codec_regfile_bench.sv
module codec_regfile_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] addr = 2'd0;
   logic       rd = 1'b0;
   logic       wr = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic       pb_tc = 1'b0;
   logic [7:0] rdata;
   logic       irq, play_en, fmt_reload;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   logic last_reload;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #5 clk = ~clk;

   codec_regfile u_codec_regfile (
      .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
      .pb_tc(pb_tc), .rdata(rdata), .irq(irq), .play_en(play_en),
      .fmt_reload(fmt_reload)
   );

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 50000) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d cycles expected<=50000", cycles);
         finish_run();
      end
   end

   // monitor: compares read data against the scoreboard
   always @(negedge clk) begin
      if (rd) begin
         logic [7:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         total++;
         if (rdata !== e) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", t, rdata, e);
         end
      end
   end

   task automatic rd_chk(input logic [1:0] a, input logic [7:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(posedge clk); #1;
      addr = a; rd = 1'b1;
      @(posedge clk); #1;
      rd = 1'b0;
   endtask

   task automatic wr_port(input logic [1:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      addr = a; wdata = d; wr = 1'b1;
      @(posedge clk); #1;
      wr = 1'b0;
      last_reload = fmt_reload;
   endtask

   task automatic wr_ind(input logic [7:0] p, input logic [7:0] d);
      wr_port(2'd0, p);
      wr_port(2'd1, d);
   endtask

   task automatic rd_ind(input logic [7:0] p, input logic [7:0] e, input string t);
      wr_port(2'd0, p);
      rd_chk(2'd1, e, t);
   endtask

   task automatic tc_pulse();
      @(posedge clk); #1;
      pb_tc = 1'b1;
      @(posedge clk); #1;
      pb_tc = 1'b0;
   endtask

   task automatic chk(input logic act, input logic e, input string t);
      total++;
      if (act !== e) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b", t, act, e);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset values
      rd_chk(2'd0, 8'h40, "R1 pointer reset");
      chk(irq, 1'b0, "R1 irq reset");
      chk(play_en, 1'b0, "R1 play_en reset");
      rd_ind(8'h4C, 8'h8A, "R1 reg12 reset");
      rd_ind(8'h49, 8'h08, "R1 reg9 reset");
      rd_ind(8'h42, 8'h88, "R1 reg2 reset");
      rd_ind(8'h46, 8'h80, "R1 reg6 reset");
      rd_ind(8'h40, 8'h00, "R1 reg0 reset");

      // R2 pointer bit 7
      wr_port(2'd0, 8'hCC);
      rd_chk(2'd0, 8'h4C, "R2 pointer bit7 dropped");

      // R3 narrow index
      rd_ind(8'h59, 8'h08, "R3 narrow index folds 25 onto 9");

      // R4 only the wide bit of reg12
      wr_ind(8'h4C, 8'hFF);
      rd_chk(2'd1, 8'hCA, "R4 reg12 only bit6");
      rd_ind(8'h59, 8'hA0, "R3 wide index reaches 25");

      // R5 protected registers
      wr_ind(8'h56, 8'h55);
      rd_chk(2'd1, 8'h00, "R5 reg22 ignored");
      wr_ind(8'h5D, 8'h11);
      rd_chk(2'd1, 8'h00, "R5 reg29 ignored");
      wr_ind(8'h5B, 8'h77);
      rd_chk(2'd1, 8'h00, "R5 reg27 ignored");
      wr_ind(8'h4B, 8'hFF);
      rd_chk(2'd1, 8'h00, "R5 reg11 read-only");

      // R6 reg9
      wr_ind(8'h49, 8'h21);
      rd_chk(2'd1, 8'h01, "R6 reg9 bit5 forced 0");
      chk(play_en, 1'b1, "R6 play_en high");
      wr_port(2'd1, 8'h00);
      chk(play_en, 1'b0, "R6 play_en low");

      // R7 / R8 format gating
      wr_ind(8'h48, 8'h5A);
      chk(last_reload, 1'b1, "R8 reload on full write");
      rd_chk(2'd1, 8'h5A, "R7 full write with mode change");
      chk(fmt_reload, 1'b0, "R8 reload lasts one cycle");
      wr_ind(8'h08, 8'h33);
      chk(last_reload, 1'b0, "R8 no reload on discard");
      rd_chk(2'd1, 8'h5A, "R7 write discarded");
      wr_ind(8'h18, 8'h10);
      wr_ind(8'h08, 8'hC3);
      chk(last_reload, 1'b1, "R8 reload on partial write");
      rd_chk(2'd1, 8'hCA, "R7 partial write keeps low nibble");
      wr_ind(8'h18, 8'h00);

      // R12 calibration flag
      wr_ind(8'h09, 8'h08);
      wr_port(2'd0, 8'h4B);
      rd_chk(2'd1, 8'h20, "R12 busy after mode-change entry");
      rd_chk(2'd1, 8'h00, "R12 busy cleared after count");
      wr_port(2'd0, 8'h4B);
      rd_chk(2'd1, 8'h00, "R12 no load without rise");
      wr_ind(8'h09, 8'h00);
      wr_port(2'd0, 8'h0B);
      wr_port(2'd0, 8'h4B);
      rd_chk(2'd1, 8'h00, "R12 no load with calibration off");

      // R9 / R10 interrupt
      tc_pulse();
      chk(irq, 1'b1, "R9 irq set");
      rd_chk(2'd2, 8'h01, "R9 status INT");
      rd_ind(8'h58, 8'h10, "R9 reg24 flag");
      wr_port(2'd2, 8'h00);
      chk(irq, 1'b0, "R10 irq cleared");
      rd_chk(2'd2, 8'h00, "R10 status cleared");
      rd_chk(2'd1, 8'h00, "R10 reg24 flags cleared");

      // R11 flag fall
      tc_pulse();
      wr_port(2'd1, 8'h00);
      chk(irq, 1'b0, "R11 flag fall clears irq");
      rd_chk(2'd2, 8'h00, "R11 status cleared");
      tc_pulse();
      wr_port(2'd1, 8'h10);
      chk(irq, 1'b1, "R11 no fall keeps irq");
      wr_port(2'd2, 8'h00);
      wr_port(2'd1, 8'h71);
      wr_port(2'd2, 8'h00);
      rd_chk(2'd1, 8'h01, "R10 bits 6:4 cleared, others kept");

      // R9 priority
      @(posedge clk); #1;
      pb_tc = 1'b1; addr = 2'd2; wr = 1'b1;
      @(posedge clk); #1;
      pb_tc = 1'b0; wr = 1'b0;
      chk(irq, 1'b1, "R9 set wins over clear");
      wr_port(2'd2, 8'h00);

      // R13
      rd_chk(2'd3, 8'h00, "R13 pio reads zero");

      // R4 back to narrow
      wr_ind(8'h4C, 8'h00);
      rd_chk(2'd1, 8'h8A, "R4 reg12 other bits fixed");
      rd_ind(8'h59, 8'h00, "R3 narrow again folds to 9");

      repeat (3) @(posedge clk);
      finish_run();
   end
endmodule